// File: doc/BRIEF.md
# Accumulator Processor Core with Staged Fetch and Execute

This block is a small processor core built around one accumulator. Every instruction runs as a fetch phase and then an execute phase, and each phase is a fixed sequence of micro-steps. All traffic to and from memory passes through two staging registers: an address staging register drives the memory address, and a data staging register either takes the word read back or holds the word to be written. The core also keeps a program counter, an instruction register, the accumulator and a carry/borrow flag.

The core drives a synchronous single-port RAM. It sends the address, the write data and a write strobe, and it receives the read data. Read data arrives one clock after an address is presented, so every read has its own wait step. Instruction words are 12 bits wide. A 4-bit operation code sits in bits 11:8 and an 8-bit operand address in bits 7:0. The program counter moves only at the very end of the execute phase, either to the next word or to a branch target. A halt instruction freezes the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: After a synchronous active-high reset, pc_out, acc_out and carry_out are 0, halted and mem_we are 0, and the first fetch uses address 0.
- R2: Fetch takes four cycles: the PC is copied into the address register, a wait cycle follows, the returned word goes into the data register, and that word then goes into the instruction register. mem_addr equals the PC during the fetch wait cycle.
- R3: Execute starts by presenting the operand field (bits 7:0) on mem_addr. The opcode is bits 11:8, with 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 branch, 6 branch-if-zero.
- R4: Store (2) copies the accumulator into the data register and writes it to memory at the operand address with a single-cycle mem_we pulse. A store takes 8 cycles.
- R5: Load (1) sets the accumulator to the memory word at the operand address and leaves the carry flag unchanged. It takes 9 cycles.
- R6: Add (3) sets the accumulator to (acc + word) mod 4096 and sets carry to 1 exactly when the true sum exceeds 4095. It takes 9 cycles.
- R7: Subtract (4) sets the accumulator to (acc - word) mod 4096 and sets carry to 1 exactly when acc < word (borrow). It takes 9 cycles.
- R8: A non-branch instruction adds one to the PC as the last execute step, wrapping from 255 to 0.
- R9: Branch (5) loads the PC from the operand field. Branch-if-zero (6) does so only when the accumulator is 0 and otherwise adds one to the PC. Both take 6 cycles.
- R10: Halt (0) raises halted 5 cycles after its fetch begins. halted then stays high, the PC holds the halt address and no write occurs until reset.
- R11: Opcodes 7 to 15 leave the accumulator, carry and memory unchanged, add one to the PC and take 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address, driven from the address staging register |
| mem_wdata | output | 12 | Write data, driven from the data staging register |
| mem_rdata | input | 12 | Read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | 12 | Accumulator value |
| pc_out | output | 8 | Program counter value |
| carry_out | output | 1 | Carry/borrow flag of the last add or subtract |

## Verification
The assertions assume that reset is held for at least one clock edge before the core runs. They also assume that the memory returns, one cycle later, the word at the address presented; nothing in the checks depends on what that word contains. The bench supplies a synchronous RAM model that is reloaded with a program image while reset is high. Its random programs use only forward branches that end on a halt, and their stores go to a data region away from the code, so every run ends and a bench interpreter can predict it. Directed programs cover the carry and borrow edges, the PC wrap from 255 to 0, and the unused opcodes.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_HALT  = 0;
  localparam int OPC_LOAD  = 1;
  localparam int OPC_STORE = 2;
  localparam int OPC_ADD   = 3;
  localparam int OPC_SUB   = 4;
  localparam int OPC_JMP   = 5;
  localparam int OPC_JZ    = 6;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_WAIT,
    ST_F_MDR,
    ST_F_IR,
    ST_X_MAR,
    ST_X_WAIT,
    ST_X_MDR,
    ST_X_ACC,
    ST_X_STM,
    ST_X_WR,
    ST_X_PC,
    ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_load;
    logic acc_load;
    logic mem_write;
    logic pc_update;
    logic pc_jump;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              flag,
  output logic              flag_we
);

  localparam int EXT_W = DATA_W + 1;

  function automatic logic [EXT_W-1:0] wide_add(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [EXT_W-1:0] wide_sub(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y);
    logic [EXT_W-1:0] d;
    d = {1'b0, x} - {1'b0, y};
    return {(x < y), d[DATA_W-1:0]};
  endfunction

  logic [EXT_W-1:0] sum_w;
  logic [EXT_W-1:0] dif_w;

  assign sum_w = wide_add(a, b);
  assign dif_w = wide_sub(a, b);

  always_comb begin
    res     = b;
    flag    = 1'b0;
    flag_we = 1'b0;
    case (op)
      ALU_ADD: begin
        res     = sum_w[DATA_W-1:0];
        flag    = sum_w[DATA_W];
        flag_we = 1'b1;
      end
      ALU_SUB: begin
        res     = dif_w[DATA_W-1:0];
        flag    = dif_w[DATA_W];
        flag_we = 1'b1;
      end
      default: begin
        res     = b;
        flag    = 1'b0;
        flag_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            acc_zero,
  output ctl_t            ctl,
  output alu_op_e         alu_op,
  output logic            halted,
  output logic            ev_fetch_wait,
  output logic            ev_exec_wait
);

  seq_state_e state_q, state_d;

  logic is_halt, is_load, is_store, is_add, is_sub, is_jmp, is_jz;

  assign is_halt  = (opcode == OP_W'(OPC_HALT));
  assign is_load  = (opcode == OP_W'(OPC_LOAD));
  assign is_store = (opcode == OP_W'(OPC_STORE));
  assign is_add   = (opcode == OP_W'(OPC_ADD));
  assign is_sub   = (opcode == OP_W'(OPC_SUB));
  assign is_jmp   = (opcode == OP_W'(OPC_JMP));
  assign is_jz    = (opcode == OP_W'(OPC_JZ));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_F_MAR:  state_d = ST_F_WAIT;
      ST_F_WAIT: state_d = ST_F_MDR;
      ST_F_MDR:  state_d = ST_F_IR;
      ST_F_IR:   state_d = ST_X_MAR;
      ST_X_MAR: begin
        if (is_halt)                           state_d = ST_HALT;
        else if (is_load || is_add || is_sub)  state_d = ST_X_WAIT;
        else if (is_store)                     state_d = ST_X_STM;
        else                                   state_d = ST_X_PC;
      end
      ST_X_WAIT: state_d = ST_X_MDR;
      ST_X_MDR:  state_d = ST_X_ACC;
      ST_X_ACC:  state_d = ST_X_PC;
      ST_X_STM:  state_d = ST_X_WR;
      ST_X_WR:   state_d = ST_X_PC;
      ST_X_PC:   state_d = ST_F_MAR;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_F_MAR;
    else     state_q <= state_d;
  end

  always_comb begin
    ctl              = '0;
    ctl.mar_from_pc  = (state_q == ST_F_MAR);
    ctl.mdr_from_mem = (state_q == ST_F_MDR) || (state_q == ST_X_MDR);
    ctl.ir_load      = (state_q == ST_F_IR);
    ctl.mar_from_ir  = (state_q == ST_X_MAR);
    ctl.mdr_from_acc = (state_q == ST_X_STM);
    ctl.mem_write    = (state_q == ST_X_WR);
    ctl.acc_load     = (state_q == ST_X_ACC);
    ctl.pc_update    = (state_q == ST_X_PC);
    ctl.pc_jump      = (state_q == ST_X_PC) && (is_jmp || (is_jz && acc_zero));
  end

  always_comb begin
    if (is_add)      alu_op = ALU_ADD;
    else if (is_sub) alu_op = ALU_SUB;
    else             alu_op = ALU_PASS;
  end

  assign halted        = (state_q == ST_HALT);
  assign ev_fetch_wait = (state_q == ST_F_WAIT);
  assign ev_exec_wait  = (state_q == ST_X_WAIT);

  // R4: a write strobe never lasts past one cycle
  assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |=> !ctl.mem_write);

  // R10: once halted, the sequencer stays halted
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctl_t                     ctl,
  input  logic [DATA_W-1:0]        alu_res,
  input  logic                     alu_flag,
  input  logic                     alu_flag_we,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     ev_fetch_wait,
  input  logic                     ev_exec_wait,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0]        acc,
  output logic [DATA_W-1:0]        mdr,
  output logic [ADDR_W-1:0]        pc,
  output logic                     carry,
  output logic                     acc_zero
);

  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic              carry_q;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ctl.mar_from_pc)       mar_q <= pc_q;
      else if (ctl.mar_from_ir)  mar_q <= ir_addr;

      if (ctl.mdr_from_mem)      mdr_q <= mem_rdata;
      else if (ctl.mdr_from_acc) mdr_q <= acc_q;

      if (ctl.ir_load)           ir_q <= mdr_q;

      if (ctl.acc_load) begin
        acc_q <= alu_res;
        if (alu_flag_we) carry_q <= alu_flag;
      end

      if (ctl.pc_update) begin
        if (ctl.pc_jump) pc_q <= ir_addr;
        else             pc_q <= pc_q + ADDR_W'(1);
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign opcode    = ir_q[DATA_W-1 -: OP_W];
  assign acc       = acc_q;
  assign mdr       = mdr_q;
  assign pc        = pc_q;
  assign carry     = carry_q;
  assign acc_zero  = (acc_q == '0);

  // R2: during the fetch wait the address bus carries the program counter
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_wait |-> (mem_addr == pc_q));

  // R3: during the operand wait the address bus carries the operand field
  assert_exec_addr_R3: assert property (@(posedge clk) disable iff (rst)
    ev_exec_wait |-> (mem_addr == ir_addr));

  // R4: the written word is the accumulator
  assert_store_data_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |-> (mem_wdata == acc_q));

  // R8: the program counter holds through every step but the last execute step
  assert_pc_late_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.ir_load || ctl.mar_from_ir || ctl.acc_load) |=> $stable(pc_q));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              carry_out
);

  localparam int OP_W = DATA_W - ADDR_W;

  ctl_t              ctl;
  alu_op_e           alu_op;
  logic [OP_W-1:0]   opcode;
  logic              acc_zero;
  logic              ev_fetch_wait, ev_exec_wait;
  logic [DATA_W-1:0] alu_res, acc_w, mdr_w;
  logic              alu_flag, alu_flag_we;

  acc_seq #(.OP_W(OP_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .acc_zero      (acc_zero),
    .ctl           (ctl),
    .alu_op        (alu_op),
    .halted        (halted),
    .ev_fetch_wait (ev_fetch_wait),
    .ev_exec_wait  (ev_exec_wait)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (alu_op),
    .a       (acc_w),
    .b       (mdr_w),
    .res     (alu_res),
    .flag    (alu_flag),
    .flag_we (alu_flag_we)
  );

  acc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk           (clk),
    .rst           (rst),
    .ctl           (ctl),
    .alu_res       (alu_res),
    .alu_flag      (alu_flag),
    .alu_flag_we   (alu_flag_we),
    .mem_rdata     (mem_rdata),
    .ev_fetch_wait (ev_fetch_wait),
    .ev_exec_wait  (ev_exec_wait),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .opcode        (opcode),
    .acc           (acc_w),
    .mdr           (mdr_w),
    .pc            (pc_out),
    .carry         (carry_out),
    .acc_zero      (acc_zero)
  );

  assign mem_we  = ctl.mem_write;
  assign acc_out = acc_w;

  // R10: a halted core keeps its PC and never writes
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc_out) && !mem_we));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata;
  logic [11:0] mem_rdata;
  logic        mem_we;
  logic        halted;
  logic [11:0] acc_out;
  logic [7:0]  pc_out;
  logic        carry_out;

  always #10 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted),
    .acc_out(acc_out), .pc_out(pc_out), .carry_out(carry_out)
  );

  logic [11:0] img [256];
  logic [11:0] ram [256];
  logic [11:0] mm  [256];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= img[i];
      mem_rdata <= 12'h0;
    end else begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [12:0] b_add(input logic [11:0] x, input logic [11:0] y);
    int s;
    s = int'(x) + int'(y);
    return {(s > 4095), 12'(s % 4096)};
  endfunction

  function automatic logic [12:0] b_sub(input logic [11:0] x, input logic [11:0] y);
    int s;
    s = int'(x) - int'(y);
    if (s < 0) s = s + 4096;
    return {(x < y), 12'(s)};
  endfunction

  function automatic logic [11:0] ins(input int op, input int ad);
    return {4'(op), 8'(ad)};
  endfunction

  logic [11:0] e_acc;
  logic        e_c;
  logic [7:0]  e_pc;
  int          e_edges, e_st;

  task automatic model_run();
    logic [11:0] w;
    logic [7:0]  ad;
    logic [12:0] r;
    bit          done;
    int          steps;
    for (int i = 0; i < 256; i++) mm[i] = img[i];
    e_acc = '0; e_c = 1'b0; e_pc = '0; e_edges = 0; e_st = 0;
    done = 1'b0; steps = 0;
    while (!done && steps < 4000) begin
      steps++;
      w  = mm[e_pc];
      ad = w[7:0];
      case (int'(w[11:8]))
        0: begin e_edges += 5; done = 1'b1; end
        1: begin e_acc = mm[ad]; e_pc++; e_edges += 9; end
        2: begin mm[ad] = e_acc; e_st++; e_pc++; e_edges += 8; end
        3: begin r = b_add(e_acc, mm[ad]); e_acc = r[11:0]; e_c = r[12]; e_pc++; e_edges += 9; end
        4: begin r = b_sub(e_acc, mm[ad]); e_acc = r[11:0]; e_c = r[12]; e_pc++; e_edges += 9; end
        5: begin e_pc = ad; e_edges += 6; end
        6: begin if (e_acc == 0) e_pc = ad; else e_pc++; e_edges += 6; end
        default: begin e_pc++; e_edges += 6; end
      endcase
    end
  endtask

  task automatic run_check(input string name, input bit trace);
    int edges, wes, bad;
    logic [7:0] hpc;
    logic [11:0] hacc;
    model_run();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    if (trace) begin
      chk(pc_out == 0 && acc_out == 0 && carry_out == 0, "R1", "pc/acc/carry after reset",
          {pc_out, acc_out, 3'b0, carry_out}, 0);
      chk(!halted && !mem_we, "R1", "halted/we after reset", {halted, mem_we}, 0);
    end
    rst = 1'b0;
    edges = 0; wes = 0;
    while (!halted && edges < 5000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (mem_we) wes++;
      if (trace && edges == 1)
        chk(mem_addr == 8'h00, "R1 R2", "first fetch address", mem_addr, 0);
      if (trace && edges == 5)
        chk(mem_addr == img[0][7:0], "R3", "operand address on bus", mem_addr, img[0][7:0]);
      if (trace && edges == 10)
        chk(mem_addr == 8'h01, "R2", "second fetch address", mem_addr, 1);
    end
    chk(halted, "R10", {name, " halted"}, halted, 1);
    chk(edges == e_edges, "R2 R4 R5 R9 R10 R11", {name, " cycles to halt"}, edges, e_edges);
    chk(acc_out == e_acc, "R5 R6 R7 R11", {name, " accumulator"}, acc_out, e_acc);
    chk(carry_out == e_c, "R6 R7 R11", {name, " carry"}, carry_out, e_c);
    chk(pc_out == e_pc, "R8 R9 R10", {name, " pc at halt"}, pc_out, e_pc);
    chk(wes == e_st, "R4", {name, " write pulses"}, wes, e_st);
    hpc = pc_out; hacc = acc_out; wes = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (mem_we) wes++;
    end
    chk(halted && pc_out == hpc && acc_out == hacc && wes == 0, "R10",
        {name, " halt holds"}, {halted, pc_out}, {1'b1, hpc});
    bad = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== mm[i]) bad++;
    chk(bad == 0, "R4 R11", {name, " memory mismatches"}, bad, 0);
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 12'h000;
  endtask

  initial begin
    #(200000 * 20);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_img();
    // carry and borrow edges, branch-if-zero taken
    img[8'h80] = 12'hFFF; img[8'h81] = 12'h001;
    img[0] = ins(1, 8'h80); img[1] = ins(3, 8'h81); img[2] = ins(2, 8'h82);
    img[3] = ins(6, 5);     img[4] = ins(0, 0);     img[5] = ins(4, 8'h81);
    img[6] = ins(2, 8'h83); img[7] = ins(0, 0);
    run_check("carry_borrow", 1'b1);
    chk(acc_out == 12'hFFF && carry_out, "R7", "0 minus 1 borrow", {carry_out, acc_out}, 13'h1FFF);
    chk(ram[8'h82] == 12'h000, "R6", "FFF plus 1 stored", ram[8'h82], 0);
    run_check("reset_again", 1'b1);

    // PC wrap 255 -> 0, branch-if-zero taken then not taken
    clear_img();
    img[0] = ins(6, 253); img[1] = ins(0, 0);
    img[252] = 12'h001;   img[253] = ins(1, 252);
    img[254] = 12'h7AA;   img[255] = 12'h800;
    run_check("pc_wrap", 1'b0);
    chk(pc_out == 8'h01 && acc_out == 12'h001, "R8", "wrap reaches halt at 1", pc_out, 1);

    // unused opcodes have no effect; load keeps carry
    clear_img();
    img[8'h80] = 12'h123; img[8'h81] = 12'hF00; img[8'h84] = 12'h555;
    img[0] = ins(1, 8'h80); img[1] = ins(3, 8'h81); img[2] = 12'h780;
    img[3] = 12'hF81;       img[4] = 12'h9AB;       img[5] = ins(1, 8'h84);
    img[6] = ins(0, 0);
    run_check("unused_ops", 1'b0);
    chk(acc_out == 12'h555 && carry_out, "R5 R11", "carry kept across load", {carry_out, acc_out}, 13'h1555);
    chk(ram[8'h80] == 12'h123 && ram[8'h81] == 12'hF00, "R11", "data untouched", ram[8'h81], 12'hF00);

    // random forward programs
    for (int t = 0; t < 20; t++) begin
      int len, r, tgt;
      clear_img();
      for (int i = 128; i < 192; i++) begin
        r = int'($urandom % 10);
        if (r == 0) img[i] = 12'h000;
        else if (r == 1) img[i] = 12'hFFF;
        else img[i] = 12'($urandom);
      end
      len = 6 + int'($urandom % 24);
      for (int i = 0; i < len; i++) begin
        r   = int'($urandom % 16);
        tgt = i + 1 + int'($urandom % (len - i));
        if (r < 3)       img[i] = ins(1, 128 + int'($urandom % 64));
        else if (r < 5)  img[i] = ins(2, 128 + int'($urandom % 64));
        else if (r < 8)  img[i] = ins(3, 128 + int'($urandom % 64));
        else if (r < 11) img[i] = ins(4, 128 + int'($urandom % 64));
        else if (r == 12) img[i] = ins(5, tgt);
        else if (r == 13) img[i] = ins(6, tgt);
        else if (r == 14) img[i] = ins(7 + int'($urandom % 9), int'($urandom % 256));
        else             img[i] = ins(1, 128 + int'($urandom % 64));
      end
      img[len] = ins(0, 0);
      run_check($sformatf("random_%0d", t), 1'b0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule